// File: doc/BRIEF.md
# SPI FPGA Configuration Loader

This block is a hardware master that writes a configuration image into the SRAM of a target FPGA configured as a slave-mode SPI device. It drives the target's active-low reset, chip select and SPI clock and data lines, and it samples the target's configuration-complete output. A host asks for a load with a single-cycle start strobe. The start carries the SPI clock divider, the clock-phase setting and a partial-reconfiguration flag. The host then supplies the image as a byte stream with valid/ready handshaking and marks the final byte with a last flag.

After a start is accepted, the block runs a fixed sequence. It holds the target in reset with the chip select low. It releases reset and confirms that the target has cleared its complete flag. It waits out the target's internal housekeeping time with the chip select still low, then pulses the chip select high for one cycle. It then streams the image most significant bit first in SPI mode 0. When the stream ends, it checks the complete flag again. On success it clocks out seven zero bytes so that the loaded design starts.

All delays are counted in system clock cycles and are derived from parameters for the clock frequency and the minimum times, always rounded up. The result is reported through a busy level, a one-cycle done pulse and a 3-bit error code that holds until the next start.

Top module: `spi_cfg_loader`

## Requirements
- R1: An accepted start drives `tgt_rst_n` and `tgt_cs_n` low on the same clock edge. `tgt_rst_n` stays low for at least ceil(RST_NS × CLK_KHZ / 10^6) cycles, and `tgt_cs_n` is low for the whole time `tgt_rst_n` is low.
- R2: When reset is released, `tgt_cs_n` stays low and `tgt_done` is sampled in the next cycle. If it is high, the load ends with error code 1 (reset failure), `tgt_cs_n` goes high and no SPI clock is produced.
- R3: After a good reset check, `tgt_cs_n` stays low for at least ceil(HK_NS × CLK_KHZ / 10^6) cycles counted from the release of reset. It is then high for at least one cycle, and it is low again for the whole image and padding phase.
- R4: Each byte is sent most significant bit first in SPI mode 0. `tgt_sck` idles low, `tgt_mosi` changes only while `tgt_sck` is low, and each high and each low half-period of `tgt_sck` lasts exactly `sck_div` cycles.
- R5: The divider is legal only within DIV_MIN = ceil(CLK_KHZ / (2 × SCK_MAX_KHZ)) to DIV_MAX = floor(CLK_KHZ / (2 × SCK_MIN_KHZ)), which is 5 to 125 at the defaults. A start with `sck_div` outside that range, or with `cpha` = 1, ends with error code 4 (parameter error), and the target pins are not touched.
- R6: A start with `start_partial` = 1 ends with error code 3 (unsupported) without touching the target pins. This check takes priority over the parameter check.
- R7: `bs_ready` is high only while the block waits for the next image byte, with the chip select low, reset released and the clock idle. Each byte is accepted on a cycle where `bs_valid` and `bs_ready` are both high, and `bs_last` on an accepted byte ends the image.
- R8: If `tgt_done` is low after the last image bit, the load ends with error code 2 (load failure), `tgt_cs_n` goes high and no padding is sent.
- R9: If `tgt_done` is high after the last image bit, exactly seven 0x00 bytes (56 clocks) follow with the chip select low, and the load ends with error code 0.
- R10: `busy` is high from the edge that accepts a start until the load ends. `done_pulse` is high for exactly one cycle at the end of every start, whether it was accepted or rejected.
- R11: `err_code` (0 none, 1 reset failure, 2 load failure, 3 unsupported, 4 parameter error) is cleared to 0 by an accepted start and otherwise changes only at the end of a start. A start that arrives while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle load request |
| start_partial | input | 1 | Marks the request as partial reconfiguration |
| cpha | input | 1 | Requested SPI clock phase (must be 0) |
| sck_div | input | DIV_W | SPI half-period in system clock cycles |
| bs_data | input | 8 | Image byte |
| bs_valid | input | 1 | Image byte valid |
| bs_last | input | 1 | Image byte is the final one |
| bs_ready | output | 1 | Block can take an image byte |
| tgt_rst_n | output | 1 | Target reset, active low |
| tgt_cs_n | output | 1 | Target SPI chip select, active low |
| tgt_sck | output | 1 | SPI clock to target |
| tgt_mosi | output | 1 | SPI data to target |
| tgt_done | input | 1 | Target configuration-complete flag |
| busy | output | 1 | Load in progress |
| done_pulse | output | 1 | One-cycle end-of-request strobe |
| err_code | output | 3 | Result code of the last request |

## Verification
The assertions assume that `tgt_done` is already synchronous to `clk` and that `start` is never raised during the cycle in which a previous request's done pulse is driven. The bench drives `tgt_done` only between operations, or while the image is still being shifted, at a falling clock edge. It spaces its start strobes several idle cycles apart. It also holds `bs_valid` high before the image phase, so the ready gating is exercised against a host that is always willing to send.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

    typedef enum logic [2:0] {
        ERR_NONE  = 3'd0,
        ERR_RESET = 3'd1,
        ERR_LOAD  = 3'd2,
        ERR_UNSUP = 3'd3,
        ERR_PARAM = 3'd4
    } err_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RHOLD,
        ST_RCHECK,
        ST_HKEEP,
        ST_GAP,
        ST_LOAD,
        ST_LSHIFT,
        ST_DCHECK,
        ST_PAD,
        ST_PSHIFT
    } st_e;

    // activation needs 49 clocks, delivered as whole bytes
    localparam int ACT_CLOCKS = 49;
    localparam int PAD_BYTES  = (ACT_CLOCKS + 7) / 8;

    // minimum time in ns converted to clock cycles, rounded up
    function automatic int ns_to_cycles(input longint ns, input longint khz);
        return int'((ns * khz + 64'd999_999) / 64'd1_000_000);
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cfgld_timer.sv
module cfgld_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] value,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= value;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    // R1
    timer_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/cfgld_start_gate.sv
module cfgld_start_gate
    import cfgld_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int DIV_MIN = 5,
    parameter int DIV_MAX = 125
) (
    input  logic             partial,
    input  logic             cpha,
    input  logic [DIV_W-1:0] div,
    output logic             reject,
    output err_e             code
);
    localparam logic [DIV_W-1:0] LO = DIV_W'(DIV_MIN);
    localparam logic [DIV_W-1:0] HI = DIV_W'(DIV_MAX);

    logic div_bad;

    always_comb begin
        div_bad = (div < LO) || (div > HI);
        reject  = 1'b0;
        code    = ERR_NONE;
        if (partial) begin
            reject = 1'b1;
            code   = ERR_UNSUP;
        end else if (cpha || div_bad) begin
            reject = 1'b1;
            code   = ERR_PARAM;
        end
    end

endmodule

// File: rtl/cfgld_shifter.sv
module cfgld_shifter #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [7:0]       byte_in,
    input  logic [DIV_W-1:0] div,
    output logic             sck,
    output logic             mosi,
    output logic             fin
);
    logic [7:0]       sr;
    logic [2:0]       bits;
    logic             active;
    logic             hi_phase;
    logic [DIV_W-1:0] cnt;
    logic             tick;

    assign tick = active && (cnt == '0);
    assign fin  = tick && hi_phase && (bits == 3'd7);
    assign mosi = active ? sr[7] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr       <= '0;
            bits     <= '0;
            active   <= 1'b0;
            hi_phase <= 1'b0;
            cnt      <= '0;
            sck      <= 1'b0;
        end else if (load && !active) begin
            sr       <= byte_in;
            bits     <= '0;
            active   <= 1'b1;
            hi_phase <= 1'b0;
            cnt      <= div - 1'b1;
            sck      <= 1'b0;
        end else if (tick) begin
            cnt <= div - 1'b1;
            if (!hi_phase) begin
                sck      <= 1'b1;
                hi_phase <= 1'b1;
            end else begin
                sck      <= 1'b0;
                hi_phase <= 1'b0;
                if (bits == 3'd7) begin
                    active <= 1'b0;
                end else begin
                    sr   <= {sr[6:0], 1'b0};
                    bits <= bits + 1'b1;
                end
            end
        end else if (active) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R4
    mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(mosi));

    // R4
    sck_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !active |-> !sck);

endmodule

// File: rtl/spi_cfg_loader.sv
module spi_cfg_loader
    import cfgld_pkg::*;
#(
    parameter int CLK_KHZ     = 250_000,
    parameter int RST_NS      = 1_000,
    parameter int HK_NS       = 1_200_000,
    parameter int SCK_MIN_KHZ = 1_000,
    parameter int SCK_MAX_KHZ = 25_000,
    parameter int DIV_W       = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             start_partial,
    input  logic             cpha,
    input  logic [DIV_W-1:0] sck_div,
    input  logic [7:0]       bs_data,
    input  logic             bs_valid,
    input  logic             bs_last,
    output logic             bs_ready,
    output logic             tgt_rst_n,
    output logic             tgt_cs_n,
    output logic             tgt_sck,
    output logic             tgt_mosi,
    input  logic             tgt_done,
    output logic             busy,
    output logic             done_pulse,
    output logic [2:0]       err_code
);
    localparam int RST_CYC = ns_to_cycles(longint'(RST_NS), longint'(CLK_KHZ));
    localparam int HK_CYC  = ns_to_cycles(longint'(HK_NS), longint'(CLK_KHZ));
    localparam int TW      = $clog2(imax(RST_CYC, HK_CYC) + 1);
    localparam int DIV_MIN = (CLK_KHZ + 2 * SCK_MAX_KHZ - 1) / (2 * SCK_MAX_KHZ);
    localparam int DIV_MAX = CLK_KHZ / (2 * SCK_MIN_KHZ);
    localparam logic [TW-1:0] RST_LD = TW'(RST_CYC);
    localparam logic [TW-1:0] HK_LD  = TW'(HK_CYC);
    localparam int PW = $clog2(PAD_BYTES + 1);

    st_e              st;
    err_e             err_q;
    logic             rst_n_q, cs_n_q, done_q;
    logic [DIV_W-1:0] div_q;
    logic [PW-1:0]    pad_left;
    logic             last_q;

    logic             reject;
    err_e             rej_code;
    logic             tm_load, tm_zero;
    logic [TW-1:0]    tm_val;
    logic             sh_load, sh_fin;
    logic [7:0]       sh_byte;
    logic             accept;

    cfgld_start_gate #(
        .DIV_W(DIV_W), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX)
    ) u_gate (
        .partial(start_partial),
        .cpha   (cpha),
        .div    (sck_div),
        .reject (reject),
        .code   (rej_code)
    );

    cfgld_timer #(.TW(TW)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .load (tm_load),
        .value(tm_val),
        .zero (tm_zero)
    );

    cfgld_shifter #(.DIV_W(DIV_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .load   (sh_load),
        .byte_in(sh_byte),
        .div    (div_q),
        .sck    (tgt_sck),
        .mosi   (tgt_mosi),
        .fin    (sh_fin)
    );

    assign accept = (st == ST_IDLE) && start && !reject;

    always_comb begin
        tm_load = accept || ((st == ST_RCHECK) && !tgt_done);
        tm_val  = (st == ST_IDLE) ? RST_LD : HK_LD;
        sh_load = ((st == ST_LOAD) && bs_valid) || (st == ST_PAD);
        sh_byte = (st == ST_LOAD) ? bs_data : 8'h00;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            err_q    <= ERR_NONE;
            rst_n_q  <= 1'b1;
            cs_n_q   <= 1'b1;
            done_q   <= 1'b0;
            div_q    <= DIV_W'(DIV_MIN);
            pad_left <= '0;
            last_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (st)
                ST_IDLE: begin
                    if (start) begin
                        if (reject) begin
                            err_q  <= rej_code;
                            done_q <= 1'b1;
                        end else begin
                            err_q   <= ERR_NONE;
                            div_q   <= sck_div;
                            rst_n_q <= 1'b0;
                            cs_n_q  <= 1'b0;
                            st      <= ST_RHOLD;
                        end
                    end
                end
                ST_RHOLD: begin
                    if (tm_zero) begin
                        rst_n_q <= 1'b1;
                        st      <= ST_RCHECK;
                    end
                end
                ST_RCHECK: begin
                    if (tgt_done) begin
                        err_q  <= ERR_RESET;
                        cs_n_q <= 1'b1;
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end else begin
                        st <= ST_HKEEP;
                    end
                end
                ST_HKEEP: begin
                    if (tm_zero) begin
                        cs_n_q <= 1'b1;
                        st     <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    cs_n_q <= 1'b0;
                    st     <= ST_LOAD;
                end
                ST_LOAD: begin
                    if (bs_valid) begin
                        last_q <= bs_last;
                        st     <= ST_LSHIFT;
                    end
                end
                ST_LSHIFT: begin
                    if (sh_fin)
                        st <= last_q ? ST_DCHECK : ST_LOAD;
                end
                ST_DCHECK: begin
                    if (!tgt_done) begin
                        err_q  <= ERR_LOAD;
                        cs_n_q <= 1'b1;
                        done_q <= 1'b1;
                        st     <= ST_IDLE;
                    end else begin
                        pad_left <= PW'(PAD_BYTES);
                        st       <= ST_PAD;
                    end
                end
                ST_PAD: begin
                    pad_left <= pad_left - 1'b1;
                    st       <= ST_PSHIFT;
                end
                ST_PSHIFT: begin
                    if (sh_fin) begin
                        if (pad_left == '0) begin
                            cs_n_q <= 1'b1;
                            done_q <= 1'b1;
                            st     <= ST_IDLE;
                        end else begin
                            st <= ST_PAD;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign bs_ready   = (st == ST_LOAD);
    assign tgt_rst_n  = rst_n_q;
    assign tgt_cs_n   = cs_n_q;
    assign busy       = (st != ST_IDLE);
    assign done_pulse = done_q;
    assign err_code   = err_q;

    // R1
    cs_with_reset_chk: assert property (@(posedge clk) disable iff (rst)
        !tgt_rst_n |-> !tgt_cs_n);

    // R4
    sck_framed_chk: assert property (@(posedge clk) disable iff (rst)
        tgt_sck |-> (!tgt_cs_n && tgt_rst_n));

    // R7
    ready_framed_chk: assert property (@(posedge clk) disable iff (rst)
        bs_ready |-> (!tgt_cs_n && tgt_rst_n && !tgt_sck));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        (done_pulse && !start) |=> !done_pulse);

    // R11
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(err_code));

    // R6
    unsup_code_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && start_partial) |=> (err_code == 3'd3 && tgt_cs_n));

endmodule

// File: tb/spi_cfg_loader_test.sv
`timescale 1ns/1ps
module spi_cfg_loader_test;

    localparam int DIV_W  = 8;
    // 1000 ns and 2000 ns at 250 MHz, rounded up
    localparam int EXP_RST = 250;
    localparam int EXP_HK  = 500;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0, start_partial = 1'b0, cpha = 1'b0;
    logic [DIV_W-1:0] sck_div = 8'd5;
    logic [7:0]       bs_data = 8'h00;
    logic             bs_valid = 1'b0, bs_last = 1'b0;
    logic             bs_ready;
    logic             tgt_rst_n, tgt_cs_n, tgt_sck, tgt_mosi;
    logic             tgt_done = 1'b0;
    logic             busy, done_pulse;
    logic [2:0]       err_code;

    spi_cfg_loader #(
        .CLK_KHZ(250_000), .RST_NS(1_000), .HK_NS(2_000), .DIV_W(DIV_W)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .start_partial(start_partial),
        .cpha(cpha), .sck_div(sck_div), .bs_data(bs_data), .bs_valid(bs_valid),
        .bs_last(bs_last), .bs_ready(bs_ready), .tgt_rst_n(tgt_rst_n),
        .tgt_cs_n(tgt_cs_n), .tgt_sck(tgt_sck), .tgt_mosi(tgt_mosi),
        .tgt_done(tgt_done), .busy(busy), .done_pulse(done_pulse),
        .err_code(err_code)
    );

    always #2 clk = ~clk;

    int checks = 0, errs = 0;
    bit finished = 0;

    // pin monitor state
    logic prev_sck = 0, prev_rst_n = 1, prev_mosi = 0, prev_done = 0;
    int   rst_low, rst_seen, hk_len, cs_rel_bad, sck_cs_bad, mosi_bad, ready_bad;
    int   hi_len, hi_min, hi_max, done_cnt, done_dbl, pin_act, rises, bit_n;
    bit   hk_on;
    logic [7:0] sr_mon;
    logic [7:0] rx [0:31];
    int   rxn;
    logic [7:0] tx [0:15];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon();
        @(posedge clk);
        rst_low = 0; rst_seen = 0; hk_len = 0; hk_on = 0; cs_rel_bad = 0;
        sck_cs_bad = 0; mosi_bad = 0; ready_bad = 0; hi_len = 0;
        hi_min = 1000000; hi_max = 0; done_cnt = 0; done_dbl = 0;
        pin_act = 0; rises = 0; bit_n = 0; rxn = 0; sr_mon = 0;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (!tgt_rst_n) rst_low++;
            if (!prev_rst_n && tgt_rst_n) begin
                rst_seen = rst_low;
                if (tgt_cs_n) cs_rel_bad++;
                hk_on = 1; hk_len = 0;
            end
            if (hk_on) begin
                if (!tgt_cs_n) hk_len++; else hk_on = 0;
            end
            if (tgt_sck) begin
                if (!prev_sck) begin
                    rises++;
                    hi_len = 1;
                    if (tgt_cs_n) sck_cs_bad++;
                    sr_mon = {sr_mon[6:0], tgt_mosi};
                    bit_n++;
                    if (bit_n == 8) begin
                        if (rxn < 32) rx[rxn] = sr_mon;
                        rxn++;
                        bit_n = 0;
                    end
                end else hi_len++;
            end else if (prev_sck) begin
                if (hi_len < hi_min) hi_min = hi_len;
                if (hi_len > hi_max) hi_max = hi_len;
            end
            if (tgt_mosi != prev_mosi && tgt_sck) mosi_bad++;
            if (bs_ready && (tgt_cs_n || !tgt_rst_n || tgt_sck)) ready_bad++;
            if (done_pulse) begin
                done_cnt++;
                if (prev_done) done_dbl++;
            end
            if (!tgt_rst_n || !tgt_cs_n || tgt_sck) pin_act++;
        end
        prev_sck = tgt_sck; prev_rst_n = tgt_rst_n;
        prev_mosi = tgt_mosi; prev_done = done_pulse;
    end

    task automatic pulse_start(input int div, input bit ph, input bit part);
        @(negedge clk);
        sck_div = DIV_W'(div); cpha = ph; start_partial = part; start = 1'b1;
        @(negedge clk);
        start = 1'b0; cpha = 1'b0; start_partial = 1'b0;
    endtask

    task automatic stream(input int n, input bit raise_done);
        for (int i = 0; i < n; i++) begin
            bs_data = tx[i]; bs_last = (i == n - 1); bs_valid = 1'b1;
            while (!bs_ready) @(negedge clk);
            @(negedge clk);
        end
        bs_valid = 1'b0; bs_last = 1'b0;
        if (raise_done) tgt_done = 1'b1;
    endtask

    task automatic wait_idle();
        int t = 0;
        while (busy && t < 60000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check(tgt_rst_n == 1 && tgt_cs_n == 1 && tgt_sck == 0, "R10",
              "reset pins idle", {tgt_rst_n, tgt_cs_n, tgt_sck}, 3'b110);
        check(busy == 0 && bs_ready == 0 && err_code == 0, "R11",
              "reset status", {busy, bs_ready, err_code}, 0);
    endtask

    task automatic t_good_load(input int div, input int n);
        clear_mon();
        tgt_done = 1'b0;
        pulse_start(div, 0, 0);
        check(busy && !tgt_rst_n && !tgt_cs_n, "R1", "rst and cs low after start",
              {busy, tgt_rst_n, tgt_cs_n}, 3'b100);
        check(err_code == 0, "R11", "err cleared by start", err_code, 0);
        bs_valid = 1'b1; bs_data = tx[0];
        stream(n, 1'b1);
        wait_idle();
        check(rst_seen >= EXP_RST, "R1", "reset hold cycles", rst_seen, EXP_RST);
        check(cs_rel_bad == 0, "R2", "cs low at reset release", cs_rel_bad, 0);
        check(hk_len >= EXP_HK, "R3", "housekeeping cycles", hk_len, EXP_HK);
        check(sck_cs_bad == 0, "R3", "sck outside cs", sck_cs_bad, 0);
        check(hi_min == div && hi_max == div, "R4", "sck high width", hi_max, div);
        check(mosi_bad == 0, "R4", "mosi change while sck high", mosi_bad, 0);
        check(ready_bad == 0, "R7", "ready outside image phase", ready_bad, 0);
        check(rxn == n + 7, "R9", "byte count", rxn, n + 7);
        for (int i = 0; i < n; i++)
            check(rx[i] == tx[i], "R4", "image byte msb first", rx[i], tx[i]);
        for (int i = n; i < n + 7; i++)
            check(rx[i] == 8'h00, "R9", "padding byte", rx[i], 0);
        check(err_code == 0 && !busy && tgt_cs_n, "R9", "success status",
              {busy, tgt_cs_n, err_code}, 4'b0100);
        check(done_cnt == 1 && done_dbl == 0, "R10", "done pulse count", done_cnt, 1);
        tgt_done = 1'b0;
    endtask

    task automatic t_reject(input int div, input bit ph, input bit part,
                            input int exp_err, input string req);
        clear_mon();
        pulse_start(div, ph, part);
        repeat (4) @(negedge clk);
        check(err_code == exp_err, req, "reject code", err_code, exp_err);
        check(pin_act == 0, req, "pins untouched", pin_act, 0);
        check(done_cnt == 1 && !busy, "R10", "reject done pulse", done_cnt, 1);
    endtask

    task automatic t_reset_fail();
        clear_mon();
        tgt_done = 1'b1;
        pulse_start(5, 0, 0);
        wait_idle();
        check(err_code == 1, "R2", "reset failure code", err_code, 1);
        check(rises == 0 && tgt_cs_n, "R2", "no sck, cs released", rises, 0);
        check(done_cnt == 1, "R10", "done on reset failure", done_cnt, 1);
        tgt_done = 1'b0;
    endtask

    task automatic t_load_fail();
        clear_mon();
        tgt_done = 1'b0;
        tx[0] = 8'h81; tx[1] = 8'h7E;
        pulse_start(6, 0, 0);
        stream(2, 1'b0);
        wait_idle();
        check(err_code == 2, "R8", "load failure code", err_code, 2);
        check(rxn == 2 && rx[0] == 8'h81 && rx[1] == 8'h7E, "R8",
              "no padding after failure", rxn, 2);
        check(tgt_cs_n == 1, "R8", "cs released", tgt_cs_n, 1);
        repeat (20) @(negedge clk);
        check(err_code == 2, "R11", "error code held", err_code, 2);
    endtask

    task automatic t_busy_ignore();
        clear_mon();
        tgt_done = 1'b0;
        tx[0] = 8'h5A;
        pulse_start(5, 0, 0);
        repeat (10) @(negedge clk);
        pulse_start(5, 0, 1);
        repeat (3) @(negedge clk);
        check(err_code == 0 && busy, "R11", "start while busy ignored", err_code, 0);
        stream(1, 1'b1);
        wait_idle();
        check(err_code == 0 && done_cnt == 1, "R11", "single completion", done_cnt, 1);
        tgt_done = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) tx[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        tx[0] = 8'hA5; tx[1] = 8'h3C; tx[2] = 8'h01; tx[3] = 8'hFF;
        t_good_load(5, 4);
        tx[0] = 8'h96; tx[1] = 8'h80;
        t_good_load(125, 2);
        t_reject(4, 0, 0, 4, "R5");
        t_reject(126, 0, 0, 4, "R5");
        t_reject(10, 1, 0, 4, "R5");
        t_reject(10, 0, 1, 3, "R6");
        t_reject(2, 1, 1, 3, "R6");
        t_reset_fail();
        t_load_fail();
        t_busy_ignore();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule